// File: doc/BRIEF.md
# Page write buffer controller

This block sits between the slave side of a two-wire serial memory interface and its nonvolatile storage array. The bus controller first hands it the starting word address of a write transfer. The bus controller then streams in the data bytes one at a time, and finally pulses a STOP indication. The bytes are gathered in a small page buffer. The buffer is indexed by the low bits of a running address pointer, so a transfer never leaves its aligned page. Bytes beyond the page size wrap and replace the earlier bytes in arrival order.

On STOP, the block commits the buffer to the array in one wide write. That write carries a byte enable for each slot that was filled during the transfer, so the other bytes of the page keep their old contents. The block then holds a busy flag for a fixed number of clock cycles, which models the self-timed programming interval. While busy is high, the bus side must refuse acknowledges. A write-protect input can veto the commit, and a STOP with no data bytes starts nothing.

The byte input is a valid/ready stream. A byte moves only in a cycle where both `wr_valid` and `wr_ready` are high. `wr_ready` drops while the write cycle runs, and also in any cycle that carries an address load or a STOP. A held byte therefore waits and is never lost. The address load, STOP and write-protect inputs are plain control pins.

Top module: `pwb_ctrl`

## Requirements
- R1: After reset, `busy` and `mem_we` are 0, `wr_ready` is 1 and `ptr` is 0.
- R2: An `addr_load` pulse while not busy sets `ptr` to `addr_in` one cycle later and empties the page buffer.
- R3: Each accepted byte increments only the low 3 bits of `ptr`, modulo 8; bits 7:3 stay unchanged for the whole transfer.
- R4: A STOP while not busy, with at least one byte buffered and `wp` low, pulses `mem_we` high for exactly one cycle, starting the next cycle. `mem_addr` is the page base, which is `ptr` with bits 2:0 cleared. `mem_be` bit k is 1 exactly when slot k (address low bits equal to k) received a byte. Byte k of `mem_wdata`, at bits 8k+7:8k, is the last byte written to slot k. Bytes with a clear enable bit are don't care.
- R5: When more than 8 bytes arrive, the later bytes overwrite the earlier slots in order, and all 8 enable bits are set.
- R6: `busy` rises in the same cycle as `mem_we` and stays high for exactly WR_CYCLES cycles.
- R7: While `busy` is high, `wr_ready` is 0, and `addr_load`, `wr_valid` and `stop_pulse` have no effect on `ptr`, the buffer or the array port.
- R8: A STOP with `wp` high produces no `mem_we` and no `busy`, and it discards the buffered bytes.
- R9: A STOP with no byte accepted since the last address load or STOP produces no `mem_we` and no `busy`.
- R10: After a commit, `ptr` points one past the last byte written, following the in-page wrap.
- R11: Every STOP empties the buffer. The next commit enables only the slots filled in its own transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| addr_load | input | 1 | Load the starting word address |
| addr_in | input | 8 | Starting word address |
| wr_valid | input | 1 | Data byte offered |
| wr_ready | output | 1 | Data byte can be taken this cycle |
| wr_data | input | 8 | Data byte |
| stop_pulse | input | 1 | End of the write transfer |
| wp | input | 1 | Write protect; high vetoes the commit |
| mem_we | output | 1 | One-cycle array write strobe |
| mem_addr | output | 8 | Page base address for the array write |
| mem_wdata | output | 64 | Page data, with slot k in bits 8k+7:8k |
| mem_be | output | 8 | Per-slot byte enables |
| busy | output | 1 | Self-timed write cycle in progress |
| ptr | output | 8 | Current address pointer |

## Verification
The bench starts a transfer in the middle of a page and runs it past the page end. A design that carried into bits 7:3 would move to the next page and show the wrong `ptr` and enable pattern. It sends eleven bytes into one page to check that the first three slots hold the last three bytes. A design that kept the oldest bytes, or clamped the count, would fail that comparison. The bench follows a write-protected transfer with a short transfer to the same page, so that stale enable bits from the vetoed transfer would show up. It also pushes a load, a STOP and a byte into the busy window, and times busy against the parameter, to catch a controller that accepts work while programming or that miscounts the interval.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned DEF_ADDR_W     = 8;
  localparam int unsigned DEF_DATA_W     = 8;
  localparam int unsigned DEF_PAGE_BYTES = 8;

  // What a STOP does to the collected page
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_COMMIT = 2'd1,
    EV_DROP   = 2'd2
  } ev_e;
endpackage

// File: rtl/pwb_ptr.sv
module pwb_ptr #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= load_addr;
    end else if (step) begin
      ptr <= {ptr[ADDR_W-1:SLOT_W], ptr[SLOT_W-1:0] + SLOT_W'(1)};
    end
  end

  // R3: stepping never leaves the page
  assert_page_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (ptr[ADDR_W-1:SLOT_W] == $past(ptr[ADDR_W-1:SLOT_W])));
endmodule

// File: rtl/pwb_slot_buf.sv
module pwb_slot_buf #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SLOTS  = 8,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [SLOT_W-1:0]       wr_slot,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    clr,
  output logic [SLOTS*DATA_W-1:0] data_flat,
  output logic [SLOTS-1:0]        mask
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic hit;
    assign hit = wr && (wr_slot == SLOT_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_flat[k*DATA_W +: DATA_W] <= '0;
        mask[k]                       <= 1'b0;
      end else if (clr) begin
        mask[k] <= 1'b0;
      end else if (hit) begin
        data_flat[k*DATA_W +: DATA_W] <= wr_data;
        mask[k]                       <= 1'b1;
      end
    end
  end

  // R11: a clear leaves no slot marked
  assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mask == '0));

  // R4: a written slot is marked
  assert_slot_marked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |=> mask[$past(wr_slot)]);
endmodule

// File: rtl/pwb_wr_timer.sv
module pwb_wr_timer #(
  parameter int unsigned CYC = 2500000,
  localparam int unsigned CNT_W = (CYC > 1) ? $clog2(CYC) : 1,
  localparam int unsigned CHK_W = $clog2(CYC + 2) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(CYC - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CNT_W'(1);
    end
  end

  // R7: no new cycle while one is running
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R6: checker-side run counter for the busy window
  logic [CHK_W-1:0] chk_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    chk_run <= '0;
    else if (busy) chk_run <= chk_run + CHK_W'(1);
    else           chk_run <= '0;
  end

  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (chk_run == CHK_W'(CYC)));
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned PAGE_BYTES = DEF_PAGE_BYTES,
  parameter int unsigned WR_CYCLES  = 2500000,
  localparam int unsigned SLOT_W    = $clog2(PAGE_BYTES),
  localparam int unsigned PAGE_W    = PAGE_BYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stop_pulse,
  input  logic              wp,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PAGE_W-1:0] mem_wdata,
  output logic [PAGE_BYTES-1:0] mem_be,
  output logic              busy,
  output logic [ADDR_W-1:0] ptr
);
  logic                  load_ok, stop_ok, accept, clr, do_commit;
  logic [PAGE_W-1:0]     buf_data;
  logic [PAGE_BYTES-1:0] buf_mask;
  ev_e                   ev;

  assign wr_ready = !busy && !addr_load && !stop_pulse;
  assign accept   = wr_valid && wr_ready;
  assign load_ok  = addr_load && !busy;
  assign stop_ok  = stop_pulse && !busy;
  assign clr      = load_ok || stop_ok;

  always_comb begin
    ev = EV_NONE;
    if (stop_ok) ev = (|buf_mask && !wp) ? EV_COMMIT : EV_DROP;
  end
  assign do_commit = (ev == EV_COMMIT);

  pwb_ptr #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(load_ok), .load_addr(addr_in),
    .step(accept), .ptr(ptr)
  );

  pwb_slot_buf #(.DATA_W(DATA_W), .SLOTS(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr(accept), .wr_slot(ptr[SLOT_W-1:0]),
    .wr_data(wr_data), .clr(clr), .data_flat(buf_data), .mask(buf_mask)
  );

  pwb_wr_timer #(.CYC(WR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(do_commit), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
    end else begin
      mem_we <= do_commit;
      if (do_commit) begin
        mem_addr  <= {ptr[ADDR_W-1:SLOT_W], SLOT_W'(0)};
        mem_wdata <= buf_data;
        mem_be    <= buf_mask;
      end
    end
  end

  // R4: the array strobe is a single pulse
  assert_we_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R6: the write cycle covers the array strobe
  assert_busy_with_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R8: protect vetoes the commit
  assert_wp_veto_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pulse && wp) |=> !mem_we);

  // R9: nothing buffered, nothing written
  assert_empty_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pulse && buf_mask == '0) |=> !mem_we);

  // R7: no byte is taken while busy
  assert_no_take_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ptr));
endmodule

// File: tb/sim_pwb_ctrl.sv
module sim_pwb_ctrl;
  localparam int WRC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_load = 1'b0;
  logic [7:0]  addr_in = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_data = '0;
  logic        stop_pulse = 1'b0;
  logic        wp = 1'b0;
  logic        mem_we;
  logic [7:0]  mem_addr;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_be;
  logic        busy;
  logic [7:0]  ptr;

  always #2 clk = ~clk;

  pwb_ctrl #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .stop_pulse(stop_pulse), .wp(wp), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .busy(busy), .ptr(ptr)
  );

  typedef struct packed {
    logic [7:0]  a;
    logic [63:0] d;
    logic [7:0]  be;
  } item_t;

  item_t      q[$];
  logic [7:0] m_buf[8];
  logic [7:0] m_msk = '0;
  logic [7:0] m_ptr = '0;
  int checks = 0;
  int failures = 0;
  int busy_run = 0;

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] a);
    @(negedge clk);
    addr_load = 1'b1;
    addr_in   = a;
    @(negedge clk);
    addr_load = 1'b0;
    m_ptr = a;
    m_msk = '0;
  endtask

  task automatic do_byte(input logic [7:0] b);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
    wr_valid = 1'b0;
    m_buf[m_ptr[2:0]] = b;
    m_msk[m_ptr[2:0]] = 1'b1;
    m_ptr = {m_ptr[7:3], m_ptr[2:0] + 3'd1};
  endtask

  task automatic do_stop();
    item_t it;
    @(negedge clk);
    stop_pulse = 1'b1;
    if (m_msk != 0 && !wp) begin
      it.a = {m_ptr[7:3], 3'b000};
      for (int k = 0; k < 8; k++) it.d[k*8 +: 8] = m_buf[k];
      it.be = m_msk;
      q.push_back(it);
    end
    m_msk = '0;
    @(negedge clk);
    stop_pulse = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Monitor: pop expected commits, time the busy window
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (q.size() == 0) begin
          checks++;
          failures++;
          $display("FAIL R7/R8/R9 unexpected write: actual addr %0h expected none", mem_addr);
        end else begin
          item_t e;
          logic [63:0] m;
          e = q.pop_front();
          for (int k = 0; k < 8; k++) m[k*8 +: 8] = {8{e.be[k]}};
          check("R4 commit address", mem_addr, e.a);
          check("R4/R11 byte enables", mem_be, e.be);
          check("R4/R5 page data", mem_wdata & m, e.d & m);
          check("R6 busy with write", busy, 1'b1);
        end
      end
      if (busy) busy_run++;
      else if (busy_run != 0) begin
        check("R6 busy length", busy_run, WRC);
        busy_run = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual running expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 mem_we", mem_we, 0);
    check("R1 wr_ready", wr_ready, 1);
    check("R1 ptr", ptr, 0);

    // Plain three-byte write
    do_load(8'h10);
    check("R2 ptr load", ptr, 8'h10);
    do_byte(8'h11); do_byte(8'h22); do_byte(8'h33);
    check("R3 ptr step", ptr, 8'h13);
    do_stop();
    wait_idle();
    check("R10 ptr after commit", ptr, 8'h13);

    // Start mid-page, run past the page end
    do_load(8'h2D);
    for (int i = 0; i < 5; i++) do_byte(8'hA0 + 8'(i));
    check("R3 in-page wrap", ptr, 8'h2A);
    do_stop();
    wait_idle();

    // Eleven bytes into one page
    do_load(8'h40);
    for (int i = 0; i < 11; i++) do_byte(8'h50 + 8'(i));
    check("R5 ptr after overflow", ptr, 8'h43);
    do_stop();
    check("R7 ready low while busy", wr_ready, 0);
    @(negedge clk);
    addr_load = 1'b1; addr_in = 8'h99; wr_valid = 1'b1; wr_data = 8'hEE; stop_pulse = 1'b1;
    repeat (3) @(negedge clk);
    addr_load = 1'b0; wr_valid = 1'b0; stop_pulse = 1'b0;
    check("R7 ptr held while busy", ptr, 8'h43);
    wait_idle();
    check("R10 ptr after overflow commit", ptr, 8'h43);

    // Protected transfer, then a short one in the same page
    do_load(8'h50);
    do_byte(8'h61); do_byte(8'h62);
    wp = 1'b1;
    do_stop();
    check("R8 no busy under wp", busy, 0);
    check("R8 no write under wp", mem_we, 0);
    wp = 1'b0;
    do_byte(8'h63);
    do_stop();
    wait_idle();

    // STOP after only an address
    do_load(8'h60);
    do_stop();
    check("R9 no busy on empty stop", busy, 0);
    check("R9 no write on empty stop", mem_we, 0);

    // Single byte at the last slot of a page
    do_load(8'h7F);
    do_byte(8'h7E);
    do_stop();
    wait_idle();
    check("R10 ptr wraps to page start", ptr, 8'h78);

    repeat (3) @(negedge clk);
    check("R4 all expected commits seen", q.size(), 0);
    summary();
    $finish;
  end
endmodule